// File: doc/BRIEF.md
# Interrupt mask and flag unit

This block keeps the enable bits and pending flags for two interrupt sources of a small 8-bit microcontroller: a timer overflow and one external pin. Software reaches it through a byte-wide I/O register port. A timer overflow pulse sets a pending flag. Software clears that flag by writing a one to it, and the core clears it by acknowledging the overflow vector.

The external pin passes through a two-flop synchronizer. A two-bit sense selector picks low level, falling edge or rising edge. An edge is held in an internal pending bit until the core acknowledges it. A low level raises the request for as long as the pin stays low, with nothing latched. The block only observes the pin value, so the pin triggers in the same way when it is driven as an output.

Each request is gated by its own enable and by the global interrupt enable. The block presents one request line and a vector address to the core. When both sources are pending, the external source wins.

Top module: `imf_unit`

## Requirements
- R1: After reset, reads of addresses 0x38, 0x39 and 0x3B all return 0x00, and `irq_req` is 0 with `irq_vec` 0.
- R2: Bit 1 of address 0x39 (timer enable) and bit 6 of address 0x3B (external enable) are read/write. Every other bit of 0x38, 0x39 and 0x3B reads 0 and ignores writes. Any other address reads 0x00. A read is combinational on `io_addr`, and a write takes effect at the clock edge where `io_we` is high.
- R3: A `tmr_ovf` pulse sets the overflow flag (bit 1 of 0x38) at the next clock edge, whatever the enables are.
- R4: Writing 0x38 with bit 1 high clears the overflow flag, and writing it with bit 1 low leaves the flag unchanged. When a clear and an overflow pulse fall in the same cycle, the flag ends up set.
- R5: The timer request (`irq_req`=1, `irq_vec`=2) is present exactly when `gie`, the timer enable and the overflow flag are all 1. The gating is combinational.
- R6: An `irq_ack` while vector 2 is presented clears the overflow flag at that edge. An overflow pulse in the same cycle keeps the flag set.
- R7: The external request (`irq_vec`=1) is raised only when bit 6 of 0x3B and `gie` are both 1. An edge that is caught while the enable is 0 stays pending and raises the request once the enable is set.
- R8: With `sense_sel`=00 (low level), the request follows the inverted pin two cycles after a pin change and is not latched.
- R9: With `sense_sel`=10 (falling edge), a high-to-low pin change raises the request three cycles later. The request stays until an acknowledge of vector 1, and rising edges are ignored.
- R10: With `sense_sel`=11 (rising edge), a low-to-high pin change raises the request three cycles later. The request stays until an acknowledge of vector 1, and falling edges are ignored.
- R11: With `sense_sel`=01 (reserved), the pin never produces a request.
- R12: When both sources request, vector 1 is presented. An acknowledge then clears only the external pending bit, and the timer flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 6 | I/O register address |
| io_we | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| sense_sel | input | 2 | External sense: 00 low, 01 reserved, 10 falling, 11 rising |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Core acknowledge of the presented vector |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 4 | Vector address: 1 external, 2 timer, 0 none |

## Verification
Register reads and the `gie` or enable gating of requests are combinational, so they are checked in the same cycle that the input is driven. A register write, an overflow pulse or an acknowledge is due one edge later. A pin change reaches a level request after two edges (the synchronizer) and an edge request after three (synchronizer plus the edge register). Every expected item carries the cycle in which it is due. The monitor compares each item only in that cycle, at the falling clock edge, and an item that passes its cycle without being compared counts as a miscompare.

// File: rtl/imf_pkg.sv
package imf_pkg;

    localparam int unsigned TOV_BIT = 1;  // overflow flag / enable position
    localparam int unsigned XEN_BIT = 6;  // external enable position
    localparam int unsigned VEC_EXT = 1;
    localparam int unsigned VEC_TMR = 2;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RSVD = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic tov;
        logic toie;
        logic xen;
    } imf_regs_t;

endpackage

// File: rtl/imf_sync.sv
module imf_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        for (int i = STAGES - 1; i > 0; i--) begin
            sh_d[i] = sh_q[i-1];
        end
        sh_d[0] = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/imf_ext_sense.sv
module imf_ext_sense
    import imf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s,
    input  logic [1:0] sense,
    input  logic       clr,
    output logic       trig
);
    typedef struct packed {
        logic prev;
        logic pend;
    } sense_st_t;

    sense_st_t st_d, st_q;
    sense_e    mode;
    logic      rise, fall, hit;

    assign mode = sense_e'(sense);

    always_comb begin
        st_d      = st_q;
        rise      = pin_s & ~st_q.prev;
        fall      = ~pin_s & st_q.prev;
        hit       = ((mode == SENSE_RISE) & rise) | ((mode == SENSE_FALL) & fall);
        st_d.prev = pin_s;
        st_d.pend = hit | (st_q.pend & ~clr);
        unique case (mode)
            SENSE_LOW:             trig = ~pin_s;
            SENSE_FALL, SENSE_RISE: trig = st_q.pend;
            default:               trig = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1, pend: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/imf_arbiter.sv
module imf_arbiter
    import imf_pkg::*;
#(
    parameter int unsigned VEC_W = 4
) (
    input  logic             ext_req,
    input  logic             tmr_req,
    input  logic             ack,
    output logic             req,
    output logic [VEC_W-1:0] vec,
    output logic             ack_ext,
    output logic             ack_tmr
);
    always_comb begin
        req     = ext_req | tmr_req;
        ack_ext = ack & ext_req;
        ack_tmr = ack & ~ext_req & tmr_req;
        if (ext_req)      vec = VEC_W'(VEC_EXT);
        else if (tmr_req) vec = VEC_W'(VEC_TMR);
        else              vec = '0;
    end
endmodule

// File: rtl/imf_unit.sv
module imf_unit
    import imf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned VEC_W       = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] TFLAG_ADDR = ADDR_W'('h38),
    parameter logic [ADDR_W-1:0] TMASK_ADDR = ADDR_W'('h39),
    parameter logic [ADDR_W-1:0] XMASK_ADDR = ADDR_W'('h3B)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_we,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              tmr_ovf,
    input  logic              ext_pin,
    input  logic [1:0]        sense_sel,
    input  logic              gie,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);
    imf_regs_t st_d, st_q;
    logic      pin_s, ext_trig, ext_req, tmr_req, ack_ext, ack_tmr;
    logic      w1c, tov_flag;
    logic      unused_wbits;

    assign unused_wbits = ^io_wdata;
    assign tov_flag     = st_q.tov;

    imf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(pin_s)
    );

    imf_ext_sense u_sense (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .sense(sense_sel),
        .clr(ack_ext), .trig(ext_trig)
    );

    assign tmr_req = gie & st_q.toie & st_q.tov;
    assign ext_req = gie & st_q.xen & ext_trig;

    imf_arbiter #(.VEC_W(VEC_W)) u_arb (
        .ext_req(ext_req), .tmr_req(tmr_req), .ack(irq_ack),
        .req(irq_req), .vec(irq_vec), .ack_ext(ack_ext), .ack_tmr(ack_tmr)
    );

    always_comb begin
        st_d = st_q;
        w1c  = io_we & (io_addr == TFLAG_ADDR) & io_wdata[TOV_BIT];
        if (io_we && io_addr == TMASK_ADDR) st_d.toie = io_wdata[TOV_BIT];
        if (io_we && io_addr == XMASK_ADDR) st_d.xen  = io_wdata[XEN_BIT];
        st_d.tov = tmr_ovf | (st_q.tov & ~(w1c | ack_tmr));

        io_rdata = '0;
        if (io_addr == TFLAG_ADDR)      io_rdata[TOV_BIT] = st_q.tov;
        else if (io_addr == TMASK_ADDR) io_rdata[TOV_BIT] = st_q.toie;
        else if (io_addr == XMASK_ADDR) io_rdata[XEN_BIT] = st_q.xen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/imf_checker.sv
module imf_checker #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned VEC_W  = 4,
    parameter logic [ADDR_W-1:0] TFLAG_ADDR = ADDR_W'('h38),
    parameter logic [ADDR_W-1:0] TMASK_ADDR = ADDR_W'('h39)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_we,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              tmr_ovf,
    input logic              gie,
    input logic              irq_ack,
    input logic              irq_req,
    input logic [VEC_W-1:0]  irq_vec,
    input logic              tov_flag
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == TFLAG_ADDR || io_addr == TMASK_ADDR) |->
            (io_rdata[DATA_W-1:2] == '0 && io_rdata[0] == 1'b0));

    assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> tov_flag);

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && io_addr == TFLAG_ADDR && io_wdata[1] && !tmr_ovf) |=> !tov_flag);

    assert_w0_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && io_addr == TFLAG_ADDR && !io_wdata[1] && tov_flag && !irq_ack) |=> tov_flag);

    assert_gie_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_req);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && irq_vec == VEC_W'(2) && !tmr_ovf) |=> !tov_flag);

    assert_vec_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == VEC_W'(1) || irq_vec == VEC_W'(2)));

    assert_vec_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_vec == '0);

    assert_tmr_vec_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_vec == VEC_W'(2)) |-> tov_flag);
endmodule

bind imf_unit imf_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
    .TFLAG_ADDR(TFLAG_ADDR), .TMASK_ADDR(TMASK_ADDR)
) u_imf_checker (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .tmr_ovf(tmr_ovf), .gie(gie),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec), .tov_flag(tov_flag)
);

// File: tb/test_imf_unit.sv
`timescale 1ns/1ps
module test_imf_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] io_addr = 6'h00;
    logic       io_we = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       tmr_ovf = 1'b0;
    logic       ext_pin = 1'b1;
    logic [1:0] sense_sel = 2'b01;
    logic       gie = 1'b1;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [3:0] irq_vec;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;

    typedef struct {
        int         due;
        bit         is_rd;
        logic [7:0] exp_rd;
        logic       exp_req;
        logic [3:0] exp_vec;
        string      tag;
    } item_t;
    item_t sbq[$];

    imf_unit i_imf_unit (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .tmr_ovf(tmr_ovf),
        .ext_pin(ext_pin), .sense_sel(sense_sel), .gie(gie),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare each item in the cycle it is due
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                nchk++;
                if (sbq[i].is_rd) begin
                    if (io_rdata !== sbq[i].exp_rd) begin
                        nfail++;
                        $display("FAIL %s: rdata=%02h expected %02h", sbq[i].tag, io_rdata, sbq[i].exp_rd);
                    end
                end else if (irq_req !== sbq[i].exp_req || irq_vec !== sbq[i].exp_vec) begin
                    nfail++;
                    $display("FAIL %s: req/vec=%0b/%0d expected %0b/%0d", sbq[i].tag,
                             irq_req, irq_vec, sbq[i].exp_req, sbq[i].exp_vec);
                end
                sbq.delete(i);
            end else if (sbq[i].due < cyc) begin
                nchk++;
                nfail++;
                $display("FAIL %s: not compared, due %0d expected at cycle %0d", sbq[i].tag, cyc, sbq[i].due);
                sbq.delete(i);
            end
        end
    end

    task automatic push_irq(int lat, logic rq, logic [3:0] vc, string tag);
        item_t it;
        it.due = cyc + lat; it.is_rd = 1'b0; it.exp_rd = '0;
        it.exp_req = rq; it.exp_vec = vc; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic rd(logic [5:0] a, logic [7:0] e, string tag);
        item_t it;
        @(posedge clk); #1;
        io_addr = a;
        it.due = cyc; it.is_rd = 1'b1; it.exp_rd = e;
        it.exp_req = 1'b0; it.exp_vec = '0; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(posedge clk); #1;
        io_we = 1'b1; io_addr = a; io_wdata = d;
        @(posedge clk); #1;
        io_we = 1'b0;
    endtask

    task automatic pulse_tmr();
        @(posedge clk); #1; tmr_ovf = 1'b1;
        @(posedge clk); #1; tmr_ovf = 1'b0;
    endtask

    task automatic do_ack();
        @(posedge clk); #1; irq_ack = 1'b1;
        @(posedge clk); #1; irq_ack = 1'b0;
    endtask

    task automatic pin_to(logic v);
        @(posedge clk); #1; ext_pin = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run incomplete at cycle %0d expected end before 20000", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        push_irq(0, 1'b0, 4'd0, "R1 no request");
        rd(6'h38, 8'h00, "R1 flag reg");
        rd(6'h39, 8'h00, "R1 timer mask");
        rd(6'h3B, 8'h00, "R1 ext mask");

        // R2 writable bits and reserved bits
        wr(6'h39, 8'hFF); rd(6'h39, 8'h02, "R2 timer mask bits");
        wr(6'h3B, 8'hFF); rd(6'h3B, 8'h40, "R2 ext mask bits");
        wr(6'h38, 8'hFD); rd(6'h38, 8'h00, "R2 flag reserved");
        rd(6'h3A, 8'h00, "R2 unmapped address");
        wr(6'h39, 8'h00); wr(6'h3B, 8'h00);
        rd(6'h39, 8'h00, "R2 timer mask cleared");

        // R3 flag sets with enables off
        pulse_tmr();
        push_irq(0, 1'b0, 4'd0, "R5 masked overflow");
        rd(6'h38, 8'h02, "R3 flag set");

        // R4 write zero keeps, write one clears
        wr(6'h38, 8'h00); rd(6'h38, 8'h02, "R4 write zero keeps");
        wr(6'h38, 8'h02); rd(6'h38, 8'h00, "R4 write one clears");

        // R5 gating
        pulse_tmr();
        wr(6'h39, 8'h02);
        @(posedge clk); #1 gie = 1'b0;
        push_irq(0, 1'b0, 4'd0, "R5 gie low gates");
        @(posedge clk); #1 gie = 1'b1;
        push_irq(0, 1'b1, 4'd2, "R5 timer request");

        // R6 acknowledge clears
        do_ack();
        push_irq(0, 1'b0, 4'd0, "R6 ack drops request");
        rd(6'h38, 8'h00, "R6 ack clears flag");

        // R4 set wins over write-one-to-clear
        pulse_tmr();
        @(posedge clk); #1;
        io_we = 1'b1; io_addr = 6'h38; io_wdata = 8'h02; tmr_ovf = 1'b1;
        @(posedge clk); #1;
        io_we = 1'b0; tmr_ovf = 1'b0;
        rd(6'h38, 8'h02, "R4 set wins over clear");

        // R6 set wins over acknowledge
        @(posedge clk); #1; irq_ack = 1'b1; tmr_ovf = 1'b1;
        @(posedge clk); #1; irq_ack = 1'b0; tmr_ovf = 1'b0;
        push_irq(0, 1'b1, 4'd2, "R6 set wins over ack");
        do_ack();
        push_irq(0, 1'b0, 4'd0, "R6 second ack");

        // R11 reserved sense
        wr(6'h3B, 8'h40);
        pin_to(1'b0); idle(5);
        push_irq(0, 1'b0, 4'd0, "R11 reserved low pin");
        pin_to(1'b1); idle(5);
        push_irq(0, 1'b0, 4'd0, "R11 reserved high pin");

        // R8 low level
        @(posedge clk); #1 sense_sel = 2'b00;
        push_irq(0, 1'b0, 4'd0, "R8 pin high idle");
        pin_to(1'b0);
        push_irq(1, 1'b0, 4'd0, "R8 not before two cycles");
        push_irq(2, 1'b1, 4'd1, "R8 level request");
        idle(5);
        push_irq(0, 1'b1, 4'd1, "R8 level held");
        wr(6'h3B, 8'h00);
        push_irq(0, 1'b0, 4'd0, "R7 ext disabled");
        wr(6'h3B, 8'h40);
        push_irq(0, 1'b1, 4'd1, "R7 ext re-enabled");
        pin_to(1'b1);
        push_irq(1, 1'b1, 4'd1, "R8 still low in sync");
        push_irq(2, 1'b0, 4'd0, "R8 not latched");
        idle(5);

        // R9 falling edge
        @(posedge clk); #1 sense_sel = 2'b10;
        pin_to(1'b0);
        push_irq(2, 1'b0, 4'd0, "R9 not before three cycles");
        push_irq(3, 1'b1, 4'd1, "R9 falling request");
        idle(5);
        do_ack();
        push_irq(0, 1'b0, 4'd0, "R9 ack clears");
        pin_to(1'b1); idle(5);
        push_irq(0, 1'b0, 4'd0, "R9 rising ignored");

        // R10 rising edge
        @(posedge clk); #1 sense_sel = 2'b11;
        pin_to(1'b0); idle(5);
        push_irq(0, 1'b0, 4'd0, "R10 falling ignored");
        pin_to(1'b1);
        push_irq(2, 1'b0, 4'd0, "R10 not before three cycles");
        push_irq(3, 1'b1, 4'd1, "R10 rising request");
        idle(5);
        push_irq(0, 1'b1, 4'd1, "R10 request held");

        // R12 priority
        pulse_tmr();
        push_irq(0, 1'b1, 4'd1, "R12 external wins");
        do_ack();
        push_irq(0, 1'b1, 4'd2, "R12 timer kept after ext ack");
        rd(6'h38, 8'h02, "R12 timer flag kept");
        do_ack();
        push_irq(0, 1'b0, 4'd0, "R12 all cleared");

        // R7 edge caught while disabled
        wr(6'h3B, 8'h00);
        pin_to(1'b0); idle(5);
        pin_to(1'b1);
        push_irq(3, 1'b0, 4'd0, "R7 disabled no request");
        idle(5);
        wr(6'h3B, 8'h40);
        push_irq(0, 1'b1, 4'd1, "R7 pending edge after enable");
        do_ack();
        push_irq(0, 1'b0, 4'd0, "R7 ack clears");

        idle(5);
        if (sbq.size() != 0) begin
            nfail++;
            $display("FAIL scoreboard: %0d items left expected 0", sbq.size());
        end
        finish_run();
    end
endmodule